// File: doc/BRIEF.md
# Multi-Queue Interprocessor Mailbox

This block passes 32-bit words between processors through a set of small hardware queues behind a word-addressed register window. A producer stores a word into a queue by writing that queue's message register. A consumer takes the oldest word out by reading the same register. Each queue also has two read-only views: one gives its fill level and one shows whether it is full.

Several users, typically one per processor, each own a bank of three registers. The event status register holds two event bits per queue. The even bit says the queue holds data, and the odd bit says it has room. A plain read/write mask register selects which events may interrupt. A write-only clear port removes mask bits without a read-modify-write. Each user drives one level-sensitive interrupt line that stays high while any unmasked event is pending.

An access is one cycle with `bus_sel` high. Read data appears on `bus_rdata` in the following cycle and is zero in every other cycle. The asynchronous reset is released synchronously inside the block, two clock edges after `rst_n` rises.

Top module: `ipc_mailbox`

## Requirements
- R1: A read of byte offset 0x000 returns the constant 0x4D42_0102, and writes to that offset have no effect.
- R2: A write to offset 0x040 + 4*m pushes the write data into queue m. A read of the same offset pops the oldest word, so words come out in the order they went in.
- R3: A read of offset 0x080 + 4*m returns 1 when queue m holds QUEUE_DEPTH words and 0 otherwise.
- R4: A read of offset 0x0C0 + 4*m returns the number of words held in queue m, which ranges from 0 to QUEUE_DEPTH.
- R5: A push to a full queue is dropped. The queue's contents and count are unchanged.
- R6: A pop from an empty queue returns 0 and leaves the count at 0.
- R7: In the status register of user u at offset 0x104 + 0x10*u, bit 2*m is set on every clock edge at which queue m is non-empty, and bit 2*m+1 is set on every clock edge at which queue m is not full. Both bits are sticky.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When a clear and a set meet on the same edge, the bit stays set.
- R9: The mask register of user u at offset 0x108 + 0x10*u is read/write over its low 2*NUM_QUEUES bits.
- R10: Writing 1s to offset 0x10C + 0x10*u clears the matching mask bits of user u and leaves the other bits unchanged. This offset reads as 0.
- R11: irq[u] is high exactly when status and mask of user u share a set bit.
- R12: Reads of unmapped or misaligned offsets return 0, and writes to them change no state.
- R13: During and after reset every queue is empty, every status and mask register is zero, every irq output is low and bus_rdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset into the register window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read |
| irq | output | NUM_USERS | Per-user level interrupt |

## Verification
The bench builds the block with its defaults: four queues of depth four and four users. At this size every queue can be driven from empty through full into overflow, and then drained into underflow. Every user's status bank is checked after each step, and every one of the eight mask bits of every user is walked against its interrupt line. This covers the set-wins-over-clear collision on both the data-present and the room-available bits, and the whole user decode including the slot past the last user.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam logic [31:0] MBX_REVISION = 32'h4D42_0102;
  // word-address bases of the register groups
  localparam int MSG_WBASE   = 16;
  localparam int FULL_WBASE  = 32;
  localparam int CNT_WBASE   = 48;
  localparam int USR_WBASE   = 64;
  localparam int USR_WSTRIDE = 4;

  typedef enum logic [2:0] {
    RK_NONE, RK_REV, RK_MSG, RK_FULL, RK_CNT, RK_STAT, RK_EN, RK_ECLR
  } reg_kind_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int NQ     = 4,
  parameter int NU     = 4,
  localparam int WA_W  = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_kind_e         kind,
  output logic [WA_W-1:0]   idx
);
  logic [WA_W-1:0] waddr;
  logic [WA_W-1:0] off;

  assign waddr = addr[ADDR_W-1:2];

  always_comb begin
    kind = RK_NONE;
    idx  = '0;
    off  = waddr - WA_W'(USR_WBASE);
    if (addr[1:0] != 2'b00) begin
      kind = RK_NONE;
    end else if (waddr == '0) begin
      kind = RK_REV;
    end else if (int'(waddr) >= MSG_WBASE && int'(waddr) < MSG_WBASE + NQ) begin
      kind = RK_MSG;
      idx  = waddr - WA_W'(MSG_WBASE);
    end else if (int'(waddr) >= FULL_WBASE && int'(waddr) < FULL_WBASE + NQ) begin
      kind = RK_FULL;
      idx  = waddr - WA_W'(FULL_WBASE);
    end else if (int'(waddr) >= CNT_WBASE && int'(waddr) < CNT_WBASE + NQ) begin
      kind = RK_CNT;
      idx  = waddr - WA_W'(CNT_WBASE);
    end else if (int'(waddr) >= USR_WBASE && int'(waddr) < USR_WBASE + USR_WSTRIDE * NU) begin
      idx = off >> 2;
      unique case (off[1:0])
        2'd1:    kind = RK_STAT;
        2'd2:    kind = RK_EN;
        2'd3:    kind = RK_ECLR;
        default: kind = RK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mbx_queue.sv
module mbx_queue #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              empty,
  output logic              full
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_ok, pop_ok;

  assign full  = (cnt_q == CNT_W'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign head  = mem[rd_ptr_q];

  always_comb begin
    push_ok  = push && !full;
    pop_ok   = pop && !empty;
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr_q + PTR_W'(1);
    if (pop_ok)  rd_ptr_d = (rd_ptr_q == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr_q + PTR_W'(1);
    unique case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata;
  end
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
  parameter int EV_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev_set,
  input  logic            st_w1c,
  input  logic            en_wr,
  input  logic            en_clr,
  input  logic [EV_W-1:0] wbits,
  output logic [EV_W-1:0] status,
  output logic [EV_W-1:0] enable,
  output logic            irq
);
  logic [EV_W-1:0] status_q, status_d, enable_q, enable_d;

  always_comb begin
    // set has priority over a same-cycle clear
    status_d = (status_q & ~(st_w1c ? wbits : '0)) | ev_set;
    enable_d = enable_q;
    if (en_wr)       enable_d = wbits;
    else if (en_clr) enable_d = enable_q & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= status_d;
      enable_q <= enable_d;
    end
  end

  assign status = status_q;
  assign enable = enable_q;
  assign irq    = |(status_q & enable_q);
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int NUM_QUEUES  = 4,
  parameter int QUEUE_DEPTH = 4,
  parameter int NUM_USERS   = 4,
  parameter int ADDR_W      = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic [NUM_USERS-1:0] irq
);
  localparam int WA_W  = ADDR_W - 2;
  localparam int EV_W  = 2 * NUM_QUEUES;
  localparam int CNT_W = $clog2(QUEUE_DEPTH + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  reg_kind_e       dec_kind;
  logic [WA_W-1:0] dec_idx;
  logic            wr_acc, rd_acc;
  logic [EV_W-1:0] wbits;

  assign wr_acc = bus_sel && bus_wr;
  assign rd_acc = bus_sel && !bus_wr;
  assign wbits  = bus_wdata[EV_W-1:0];

  mbx_decode #(.ADDR_W(ADDR_W), .NQ(NUM_QUEUES), .NU(NUM_USERS)) u_decode (
    .addr (bus_addr),
    .kind (dec_kind),
    .idx  (dec_idx)
  );

  logic [NUM_QUEUES-1:0]             q_push, q_pop, q_full, q_empty;
  logic [NUM_QUEUES-1:0][CNT_W-1:0]  q_count;
  logic [NUM_QUEUES-1:0][DATA_W-1:0] q_head;
  logic [EV_W-1:0]                   ev_set;

  for (genvar q = 0; q < NUM_QUEUES; q++) begin : g_queue
    assign q_push[q] = wr_acc && (dec_kind == RK_MSG) && (dec_idx == WA_W'(q));
    assign q_pop[q]  = rd_acc && (dec_kind == RK_MSG) && (dec_idx == WA_W'(q));
    assign ev_set[2*q]   = !q_empty[q];
    assign ev_set[2*q+1] = !q_full[q];

    mbx_queue #(.DATA_W(DATA_W), .DEPTH(QUEUE_DEPTH)) u_queue (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .push  (q_push[q]),
      .pop   (q_pop[q]),
      .wdata (bus_wdata),
      .head  (q_head[q]),
      .count (q_count[q]),
      .empty (q_empty[q]),
      .full  (q_full[q])
    );
  end

  logic [NUM_USERS-1:0]           u_st_w1c, u_en_wr, u_en_clr;
  logic [NUM_USERS-1:0][EV_W-1:0] u_status, u_enable;

  for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
    assign u_st_w1c[u] = wr_acc && (dec_kind == RK_STAT) && (dec_idx == WA_W'(u));
    assign u_en_wr[u]  = wr_acc && (dec_kind == RK_EN)   && (dec_idx == WA_W'(u));
    assign u_en_clr[u] = wr_acc && (dec_kind == RK_ECLR) && (dec_idx == WA_W'(u));

    mbx_user_irq #(.EV_W(EV_W)) u_user (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .ev_set (ev_set),
      .st_w1c (u_st_w1c[u]),
      .en_wr  (u_en_wr[u]),
      .en_clr (u_en_clr[u]),
      .wbits  (wbits),
      .status (u_status[u]),
      .enable (u_enable[u]),
      .irq    (irq[u])
    );
  end

  // read path
  logic [DATA_W-1:0] rd_val, rdata_d, rdata_q;

  always_comb begin
    rd_val = '0;
    if (dec_kind == RK_REV) rd_val = DATA_W'(MBX_REVISION);
    for (int q = 0; q < NUM_QUEUES; q++) begin
      if (dec_idx == WA_W'(q)) begin
        if (dec_kind == RK_MSG && !q_empty[q]) rd_val = q_head[q];
        if (dec_kind == RK_FULL)               rd_val = DATA_W'(q_full[q]);
        if (dec_kind == RK_CNT)                rd_val = DATA_W'(q_count[q]);
      end
    end
    for (int u = 0; u < NUM_USERS; u++) begin
      if (dec_idx == WA_W'(u)) begin
        if (dec_kind == RK_STAT) rd_val = DATA_W'(u_status[u]);
        if (dec_kind == RK_EN)   rd_val = DATA_W'(u_enable[u]);
      end
    end
    rdata_d = rd_acc ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rdata_q <= '0;
    else             rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
  parameter int NQ    = 4,
  parameter int NU    = 4,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3,
  parameter int EV_W  = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NQ-1:0][CNT_W-1:0] q_count,
  input logic [NQ-1:0]           q_push,
  input logic [NQ-1:0]           q_pop,
  input logic [NU-1:0][EV_W-1:0] u_status,
  input logic [NU-1:0][EV_W-1:0] u_enable,
  input logic [NU-1:0]           u_en_clr,
  input logic [EV_W-1:0]         wbits,
  input logic [NU-1:0]           irq
);
  for (genvar q = 0; q < NQ; q++) begin : g_q
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      q_count[q] <= CNT_W'(DEPTH));  // R4
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count[q] == CNT_W'(DEPTH) && q_push[q]) |=> $stable(q_count[q]));  // R5
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
      (q_count[q] == '0 && q_pop[q]) |=> (q_count[q] == '0));  // R6
    for (genvar u = 0; u < NU; u++) begin : g_u
      AST_NEWMSG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count[q] != '0) |=> u_status[u][2*q]);  // R7
      AST_ROOM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (q_count[q] != CNT_W'(DEPTH)) |=> u_status[u][2*q+1]);  // R7
    end
  end

  for (genvar u = 0; u < NU; u++) begin : g_usr
    AST_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      u_en_clr[u] |=> ((u_enable[u] & $past(wbits)) == '0));  // R10
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (u_enable[u] == '0) |-> !irq[u]);  // R11
  end
endmodule

bind ipc_mailbox mbx_checker #(
  .NQ(NUM_QUEUES), .NU(NUM_USERS), .DEPTH(QUEUE_DEPTH),
  .CNT_W($clog2(QUEUE_DEPTH + 1)), .EV_W(2 * NUM_QUEUES)
) u_mbx_checker (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .q_count  (q_count),
  .q_push   (q_push),
  .q_pop    (q_pop),
  .u_status (u_status),
  .u_enable (u_enable),
  .u_en_clr (u_en_clr),
  .wbits    (wbits),
  .irq      (irq)
);

// File: tb/test_ipc_mailbox.sv
module test_ipc_mailbox;
  localparam int NQ = 4, DEPTH = 4, NU = 4, DW = 32, AW = 9, EVW = 2 * NQ;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic [DW-1:0] bus_rdata;
  logic [NU-1:0] irq;

  always #10 clk = ~clk;  // 50 MHz

  ipc_mailbox i_ipc_mailbox (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference model
  logic [DW-1:0]  mq [NQ][$];
  logic [EVW-1:0] ms [NU];
  logic [EVW-1:0] men [NU];

  function automatic logic [EVW-1:0] events();
    logic [EVW-1:0] e;
    for (int q = 0; q < NQ; q++) begin
      e[2*q]   = (mq[q].size() != 0);
      e[2*q+1] = (mq[q].size() != DEPTH);
    end
    return e;
  endfunction

  function automatic void settle();
    for (int u = 0; u < NU; u++) ms[u] = ms[u] | events();
  endfunction

  function automatic logic [NU-1:0] exp_irq();
    logic [NU-1:0] v;
    for (int u = 0; u < NU; u++) v[u] = |(ms[u] & men[u]);
    return v;
  endfunction

  task automatic check(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [DW-1:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(addr); bus_wdata = data;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(int addr, output logic [DW-1:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(addr);
    @(negedge clk);
    bus_sel = 1'b0;
    data = bus_rdata;
    @(negedge clk);
  endtask

  task automatic check_status(string req);
    logic [DW-1:0] v;
    for (int u = 0; u < NU; u++) begin
      rd(32'h104 + 16 * u, v);
      check(req, $sformatf("status user %0d", u), v, DW'(ms[u]));
    end
  endtask

  task automatic push(int q, logic [DW-1:0] d);
    wr(32'h040 + 4 * q, d);
    if (mq[q].size() < DEPTH) mq[q].push_back(d);
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    for (int u = 0; u < NU; u++) begin ms[u] = '0; men[u] = '0; end
    repeat (3) @(negedge clk);
    check("R13", "irq in reset", DW'(irq), '0);
    check("R13", "rdata in reset", bus_rdata, '0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    settle();

    // R13 and R7: queues empty, room bits set everywhere, masks zero
    for (int q = 0; q < NQ; q++) begin
      rd(32'h0C0 + 4 * q, v);
      check("R13", $sformatf("count q%0d after reset", q), v, '0);
    end
    for (int u = 0; u < NU; u++) begin
      rd(32'h108 + 16 * u, v);
      check("R13", $sformatf("mask user %0d after reset", u), v, '0);
    end
    check_status("R7");

    // R1: revision constant, write ignored
    rd(32'h000, v);
    check("R1", "revision", v, 32'h4D42_0102);
    wr(32'h000, 32'hFFFF_FFFF);
    rd(32'h000, v);
    check("R1", "revision after write", v, 32'h4D42_0102);

    // queue sweep: fill past full, collide clear with set, drain past empty
    for (int q = 0; q < NQ; q++) begin
      for (int k = 0; k <= DEPTH; k++) begin
        push(q, 32'hC0DE_0000 + DW'(q * 256 + k));
        rd(32'h0C0 + 4 * q, v);
        check(k < DEPTH ? "R4" : "R5", $sformatf("count q%0d push %0d", q, k), v,
              DW'(mq[q].size()));
        rd(32'h080 + 4 * q, v);
        check("R3", $sformatf("full q%0d push %0d", q, k), v, DW'(mq[q].size() == DEPTH));
      end
      check_status("R7");
      // R8: clear the room bit while full -> reads 0
      wr(32'h104 + 16 * (q % NU), DW'(1) << (2 * q + 1));
      ms[q % NU][2*q+1] = 1'b0; settle();
      // R8: clear the data bit while non-empty -> set wins
      wr(32'h104 + 16 * (q % NU), DW'(1) << (2 * q));
      settle();
      // R8: writing zero changes nothing
      wr(32'h104 + 16 * (q % NU), '0);
      check_status("R8");
      for (int k = 0; k <= DEPTH; k++) begin
        logic [DW-1:0] e;
        e = (mq[q].size() != 0) ? mq[q].pop_front() : '0;
        rd(32'h040 + 4 * q, v);
        settle();
        check(k < DEPTH ? "R2" : "R6", $sformatf("pop q%0d #%0d", q, k), v, e);
      end
      rd(32'h0C0 + 4 * q, v);
      check("R6", $sformatf("count q%0d after underflow", q), v, '0);
      check_status("R7");
    end

    // R8: with queues empty, data bits clear for good
    for (int u = 0; u < NU; u++) begin
      wr(32'h104 + 16 * u, 32'hFF);
      ms[u] = '0; settle();
    end
    check_status("R8");
    push(1, 32'h1234_5678);

    // mask walk: every bit of every user against irq
    for (int u = 0; u < NU; u++) begin
      for (int b = 0; b < EVW; b++) begin
        wr(32'h108 + 16 * u, DW'(1) << b);
        men[u] = EVW'(1) << b;
        rd(32'h108 + 16 * u, v);
        check("R9", $sformatf("mask user %0d bit %0d", u, b), v, DW'(men[u]));
        check("R11", $sformatf("irq user %0d bit %0d", u, b), DW'(irq), DW'(exp_irq()));
        wr(32'h10C + 16 * u, DW'(1) << b);
        men[u] = '0;
        check("R10", $sformatf("irq after mask clear u%0d b%0d", u, b), DW'(irq), DW'(exp_irq()));
      end
      wr(32'h108 + 16 * u, 32'hFF);
      wr(32'h10C + 16 * u, 32'h0F);
      men[u] = 8'hF0;
      rd(32'h108 + 16 * u, v);
      check("R10", $sformatf("partial mask clear u%0d", u), v, 32'hF0);
      rd(32'h10C + 16 * u, v);
      check("R10", $sformatf("clear port reads zero u%0d", u), v, '0);
      check("R11", $sformatf("irq with upper mask u%0d", u), DW'(irq), DW'(exp_irq()));
    end

    // R12: unmapped and misaligned offsets
    begin
      int holes [8] = '{32'h004, 32'h03C, 32'h050, 32'h090, 32'h0D0, 32'h100, 32'h144, 32'h041};
      for (int i = 0; i < 8; i++) begin
        rd(holes[i], v);
        check("R12", $sformatf("read hole %h", holes[i]), v, '0);
        wr(holes[i], 32'hFFFF_FFFF);
      end
    end
    for (int q = 0; q < NQ; q++) begin
      rd(32'h0C0 + 4 * q, v);
      check("R12", $sformatf("count q%0d after hole writes", q), v, DW'(mq[q].size()));
    end
    for (int u = 0; u < NU; u++) begin
      rd(32'h108 + 16 * u, v);
      check("R12", $sformatf("mask user %0d after hole writes", u), v, DW'(men[u]));
    end
    check_status("R12");
    rd(32'h044, v);
    check("R2", "word kept through hole writes", v, 32'h1234_5678);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule